// File: doc/BRIEF.md
# Half to Single Precision Converter

The block widens a 16-bit half-precision floating-point pattern into the 32-bit single-precision pattern that has the same value. Every half value fits exactly in single precision, so the unit has no rounding stage. It covers every class of input: signed zeros, subnormals, normals, infinities and NaNs. Subnormals are renormalised into single-precision normals.

Two controls change the result. The alternative-format control makes the top exponent code an ordinary binade, so the format has no infinities and no NaNs. The default-NaN control replaces any propagated NaN with one canonical quiet NaN. A signalling NaN produces an invalid-operation event for that one operation. A trap-enable input decides how the event is reported: as a status flag pulse, or as a trap request. A surrounding wrapper collects the flag pulses into its sticky status register.

The unit has one register stage. An operation presented with `inValid` in one cycle returns its result and event outputs after the next rising clock edge.

Top module: `h2s_convert`

## Requirements
- R1: While reset is held and after it is released, `outValid`, `singleOut`, `invalidFlag` and `invalidTrap` are all zero until the first operation has been captured.
- R2: An operation with `inValid` high at a rising edge appears on the outputs after that edge, and `outValid` follows `inValid` with one cycle of delay. A cycle with `inValid` low leaves `singleOut` unchanged and drives `outValid`, `invalidFlag` and `invalidTrap` low.
- R3: A half input with exponent field (bits 14:10) equal to 0 and fraction (bits 9:0) equal to 0 gives a single result of the input sign (bit 15) in bit 31, with all other bits zero.
- R4: A half input with an exponent field from 1 to 30 gives a single exponent field (bits 30:23) equal to the half exponent plus 112. The half fraction goes to single bits 22:13, and bits 12:0 are zero. The sign is copied.
- R5: A half input with exponent field 0 and a nonzero fraction has the value 2^-14 × fraction/1024. It gives a normal single result with exponent field 103 + p, where p is the bit index of the fraction's leading one. The fraction bits below that leading one are left-aligned in single bits 22:13.
- R6: With `altFmt` low, exponent field 31 with fraction 0 gives a signed infinity: the sign, exponent 0xFF and fraction 0.
- R7: With `altFmt` low and `dnEnable` low, exponent field 31 with a nonzero fraction gives the following NaN. Bit 31 is the sign, bits 30:22 are all ones, bits 21:13 carry half fraction bits 8:0, and bits 12:0 are zero.
- R8: With `altFmt` low and `dnEnable` high, any NaN input gives 0x7FC00000, whatever its sign or payload.
- R9: With `altFmt` high, exponent field 31 is an ordinary normal with value 2^16 × (1 + fraction/1024). It gives exponent field 143 and the copied fraction. No result in this mode has exponent 0xFF, and no invalid event is raised.
- R10: A signalling NaN raises the invalid event for that operation and for no other. A signalling NaN is a NaN input (`altFmt` low) whose fraction bit 9 is 0. The event appears on `invalidFlag` when `invTrapEn` is low, and on `invalidTrap` when it is high. The two event outputs are never high together. Quiet NaNs and all non-NaN inputs raise neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An operation is presented this cycle |
| halfIn | input | 16 | Half-precision operand |
| altFmt | input | 1 | Top exponent code is an ordinary binade |
| dnEnable | input | 1 | Replace NaN results by the canonical quiet NaN |
| invTrapEn | input | 1 | Report invalid-operation as a trap request instead of a flag |
| outValid | output | 1 | Result registers hold a new result |
| singleOut | output | 32 | Single-precision result |
| invalidFlag | output | 1 | Invalid-operation status pulse for this result |
| invalidTrap | output | 1 | Invalid-operation trap request for this result |

## Verification
The hardest condition to reach is a signalling NaN whose payload must survive under each combination of default-NaN and trap enable. This is made harder because the same exponent code means an ordinary number once the alternative format is selected. The stimulus walks every one of the 65536 half patterns in both format modes. The default-NaN and trap-enable controls are derived from fraction bits of the running index, so each NaN class meets both settings of each control. Expected results come from a bench model that normalises subnormals by repeated doubling. A final idle phase confirms that the result holds when no operation is presented.

// File: rtl/h2s_pkg.sv
package h2s_pkg;
  parameter int HALF_EXP_W  = 5;
  parameter int HALF_FRAC_W = 10;
  parameter int SGL_EXP_W   = 8;
  parameter int SGL_FRAC_W  = 23;

  localparam int HALF_W    = 1 + HALF_EXP_W + HALF_FRAC_W;
  localparam int SGL_W     = 1 + SGL_EXP_W + SGL_FRAC_W;
  localparam int HALF_BIAS = (1 << (HALF_EXP_W - 1)) - 1;
  localparam int SGL_BIAS  = (1 << (SGL_EXP_W - 1)) - 1;
  localparam int EXP_SHIFT = SGL_BIAS - HALF_BIAS;
  localparam int SUB_BASE  = SGL_BIAS - (HALF_BIAS - 1) - HALF_FRAC_W;
  localparam int FRAC_PAD  = SGL_FRAC_W - HALF_FRAC_W;
  localparam int LEAD_W    = $clog2(HALF_FRAC_W);

  // Result-selection strobes from the classifier to the datapath
  typedef struct packed {
    logic selZero;
    logic selSub;
    logic selNorm;
    logic selInf;
    logic selNanPay;
    logic selDefNan;
  } convStrobes_t;
endpackage

// File: rtl/h2s_ctrl.sv
module h2s_ctrl
  import h2s_pkg::*;
(
  input  logic [HALF_EXP_W-1:0]  expIn,
  input  logic [HALF_FRAC_W-1:0] fracIn,
  input  logic                   altFmt,
  input  logic                   dnEnable,
  output convStrobes_t           strobes,
  output logic                   raiseInvalid
);
  logic expTop;
  logic expZero;
  logic fracZero;
  logic specialCode;
  logic nanIn;

  always_comb begin
    expTop      = &expIn;
    expZero     = (expIn == '0);
    fracZero    = (fracIn == '0);
    specialCode = expTop && !altFmt;
    nanIn       = specialCode && !fracZero;

    strobes.selZero   = expZero && fracZero;
    strobes.selSub    = expZero && !fracZero;
    strobes.selNorm   = !expZero && !specialCode;
    strobes.selInf    = specialCode && fracZero;
    strobes.selNanPay = nanIn && !dnEnable;
    strobes.selDefNan = nanIn && dnEnable;
    raiseInvalid      = nanIn && !fracIn[HALF_FRAC_W-1];
  end
endmodule

// File: rtl/h2s_path.sv
module h2s_path
  import h2s_pkg::*;
(
  input  logic [HALF_W-1:0] halfIn,
  input  convStrobes_t      strobes,
  output logic [SGL_W-1:0]  result
);
  logic                   signIn;
  logic [HALF_EXP_W-1:0]  expIn;
  logic [HALF_FRAC_W-1:0] fracIn;
  logic [LEAD_W-1:0]      leadPos;
  logic [HALF_FRAC_W-1:0] subFrac;
  logic [SGL_EXP_W-1:0]   subExp;
  logic [SGL_EXP_W-1:0]   normExp;

  assign signIn = halfIn[HALF_W-1];
  assign expIn  = halfIn[HALF_W-2 -: HALF_EXP_W];
  assign fracIn = halfIn[HALF_FRAC_W-1:0];

  // Priority encoder: index of the most significant set fraction bit
  always_comb begin
    leadPos = '0;
    for (int i = 0; i < HALF_FRAC_W; i++) begin
      if (fracIn[i]) leadPos = LEAD_W'(i);
    end
  end

  always_comb begin
    subFrac = fracIn << (LEAD_W'(HALF_FRAC_W) - leadPos);
    subExp  = SGL_EXP_W'(SUB_BASE) + SGL_EXP_W'(leadPos);
    normExp = SGL_EXP_W'(EXP_SHIFT) + SGL_EXP_W'(expIn);
  end

  always_comb begin
    result = '0;
    if (strobes.selZero)
      result = {signIn, {(SGL_W-1){1'b0}}};
    else if (strobes.selSub)
      result = {signIn, subExp, subFrac, {FRAC_PAD{1'b0}}};
    else if (strobes.selNorm)
      result = {signIn, normExp, fracIn, {FRAC_PAD{1'b0}}};
    else if (strobes.selInf)
      result = {signIn, {SGL_EXP_W{1'b1}}, {SGL_FRAC_W{1'b0}}};
    else if (strobes.selNanPay)
      result = {signIn, {SGL_EXP_W{1'b1}}, 1'b1, fracIn[HALF_FRAC_W-2:0],
                {FRAC_PAD{1'b0}}};
    else if (strobes.selDefNan)
      result = {1'b0, {SGL_EXP_W{1'b1}}, 1'b1, {(SGL_FRAC_W-1){1'b0}}};
  end
endmodule

// File: rtl/h2s_convert.sv
module h2s_convert
  import h2s_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [HALF_W-1:0] halfIn,
  input  logic              altFmt,
  input  logic              dnEnable,
  input  logic              invTrapEn,
  output logic              outValid,
  output logic [SGL_W-1:0]  singleOut,
  output logic              invalidFlag,
  output logic              invalidTrap
);
  convStrobes_t     strobes;
  logic             raiseInvalid;
  logic [SGL_W-1:0] resultNext;

  h2s_ctrl u_ctrl (
    .expIn        (halfIn[HALF_W-2 -: HALF_EXP_W]),
    .fracIn       (halfIn[HALF_FRAC_W-1:0]),
    .altFmt       (altFmt),
    .dnEnable     (dnEnable),
    .strobes      (strobes),
    .raiseInvalid (raiseInvalid)
  );

  h2s_path u_path (
    .halfIn  (halfIn),
    .strobes (strobes),
    .result  (resultNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      singleOut   <= '0;
      invalidFlag <= 1'b0;
      invalidTrap <= 1'b0;
    end else begin
      outValid    <= inValid;
      invalidFlag <= inValid && raiseInvalid && !invTrapEn;
      invalidTrap <= inValid && raiseInvalid && invTrapEn;
      if (inValid) singleOut <= resultNext;
    end
  end

  AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(singleOut) && !outValid)); // R2
  AST_NAN_QUIETED: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (&singleOut[SGL_W-2 -: SGL_EXP_W]) && (singleOut[SGL_FRAC_W-1:0] != '0))
      |-> singleOut[SGL_FRAC_W-1]); // R7
  AST_ALT_NO_SPECIAL: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && altFmt) |=> (!(&singleOut[SGL_W-2 -: SGL_EXP_W]) && !invalidFlag && !invalidTrap)); // R9
  AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(invalidFlag && invalidTrap)); // R10
  AST_EVENT_ON_NAN: assert property (@(posedge clk) disable iff (!rstN)
    (invalidFlag || invalidTrap) |-> (outValid && (&singleOut[SGL_W-2 -: SGL_EXP_W]))); // R10
endmodule

// File: tb/sim_h2s_convert.sv
`timescale 1ns/1ps
module sim_h2s_convert;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] halfIn = '0;
  logic        altFmt = 1'b0;
  logic        dnEnable = 1'b0;
  logic        invTrapEn = 1'b0;
  logic        outValid;
  logic [31:0] singleOut;
  logic        invalidFlag;
  logic        invalidTrap;

  int checkCnt = 0;
  int failCnt  = 0;

  always #10 clk = ~clk;

  h2s_convert u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .halfIn(halfIn),
    .altFmt(altFmt), .dnEnable(dnEnable), .invTrapEn(invTrapEn),
    .outValid(outValid), .singleOut(singleOut),
    .invalidFlag(invalidFlag), .invalidTrap(invalidTrap)
  );

  // Reference: returns {flag, trap, result}
  function automatic logic [33:0] refConv(logic [15:0] h, logic alt, logic dn, logic te,
                                           output string tag);
    logic        s = h[15];
    int          e = int'(h[14:10]);
    int          f = int'(h[9:0]);
    logic [31:0] res;
    logic        flg = 1'b0;
    logic        trp = 1'b0;
    int          m;
    int          ex;
    if (e == 0 && f == 0) begin
      res = {s, 31'b0}; tag = "R3";
    end else if (e == 0) begin
      m = f; ex = 113;
      while (m < 1024) begin m = m * 2; ex = ex - 1; end
      res = {s, 8'(ex), 10'(m - 1024), 13'b0}; tag = "R5";
    end else if (e == 31 && !alt) begin
      if (f == 0) begin
        res = {s, 8'hFF, 23'b0}; tag = "R6";
      end else begin
        if (dn) begin res = 32'h7FC0_0000; tag = "R8"; end
        else begin res = {s, 31'h7FC0_0000} | (32'(f % 512) << 13); tag = "R7"; end
        if (f < 512) begin
          if (te) trp = 1'b1; else flg = 1'b1;
          tag = {tag, "/R10"};
        end
      end
    end else begin
      res = {s, 8'(e + 112), 10'(f), 13'b0};
      tag = (e == 31) ? "R9" : "R4";
    end
    return {flg, trp, res};
  endfunction

  task automatic check(bit ok, string tag, logic [34:0] act, logic [34:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checkCnt - failCnt + 1, checkCnt + 1);
    $finish;
  end

  initial begin : main
    logic [33:0] expV;
    logic [33:0] prevExp;
    string       prevTag;
    string       tg;
    logic [31:0] held;
    prevExp = '0;
    prevTag = "";
    repeat (3) @(negedge clk);
    // R1: reset state
    check({outValid, singleOut, invalidFlag, invalidTrap} == '0, "R1",
          {1'b0, outValid, singleOut, invalidFlag, invalidTrap}, '0);
    rstN = 1'b1;
    @(negedge clk);
    check({outValid, singleOut, invalidFlag, invalidTrap} == '0, "R1",
          {1'b0, outValid, singleOut, invalidFlag, invalidTrap}, '0);

    for (int n = 0; n <= 131072; n++) begin
      if (n > 0) begin
        check(outValid && {invalidFlag, invalidTrap, singleOut} == prevExp,
              {prevTag, "/R2"},
              {outValid, invalidFlag, invalidTrap, singleOut}, {1'b1, prevExp});
      end
      if (n < 131072) begin
        halfIn    = 16'(n);
        altFmt    = n[16];
        dnEnable  = n[2] ^ n[7];
        invTrapEn = n[4] ^ n[8];
        inValid   = 1'b1;
        prevExp   = refConv(halfIn, altFmt, dnEnable, invTrapEn, tg);
        prevTag   = tg;
        @(negedge clk);
      end
    end

    // R2: idle cycles hold the result and clear the strobes
    held      = singleOut;
    inValid   = 1'b0;
    halfIn    = 16'h7C01;
    altFmt    = 1'b0;
    invTrapEn = 1'b0;
    dnEnable  = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!outValid && !invalidFlag && !invalidTrap && singleOut == held, "R2",
            {outValid, invalidFlag, invalidTrap, singleOut}, {3'b000, held});
    end

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule